// File: doc/BRIEF.md
# Physical Register Wakeup Scoreboard

This block tracks which physical registers hold valid results and which waiting queue entries still need which of them. A ready bit exists for every physical register. Each queue entry keeps, per source operand, a register tag and a wait bit. The set of entries whose wait bit is set for a tag forms that register's dependent list. Together these wait bits make a wakeup matrix.

The block takes four kinds of input. A destination allocation clears a register's ready bit. An insertion writes an entry and arms a wait bit only for sources that are still pending. A completion broadcast, on several ports in parallel, clears every matching wait bit and sets the register's ready bit. A kill mask removes entries from all dependent lists at once.

Each entry is a small state machine with three states. E_FREE holds no instruction. E_WAIT has at least one pending source. E_READY has every source satisfied and drives its issue_ready bit. The transitions are as follows:
- FREE to WAIT or READY on insertion.
- WAIT to READY once the last wait bit is cleared by a completion.
- WAIT or READY to FREE on kill.
- Any state to WAIT or READY when the entry is written again.

Issue selection and memory ordering are outside this block. Software is expected to kill an entry once it has issued.

Top module: `preg_wakeup_sb`

## Requirements
- R1: After reset every preg_ready bit is 0 and every issue_ready bit is 0.
- R2: An allocation of a register index below NUM_PREGS makes that preg_ready bit 0 from the next cycle on.
- R3: alloc_conflict is 1, in the same cycle, exactly when alloc_valid is set and some occupied entry still waits on alloc_preg.
- R4: On insertion, a source flagged ready by ins_src_rdy (bit s belongs to source s, field s of ins_src is bits s*TAG_W and up) never waits. A source flagged not ready whose preg_ready bit is already 1 is also treated as ready at once.
- R5: A tag at or above NUM_PREGS never waits, and a completion of such a tag changes no output.
- R6: A completion on any port sets that register's preg_ready bit and clears the matching wait bit of every waiting entry. Completions on all ports act in the same cycle.
- R7: issue_ready of an entry is 1 only when all of its sources are satisfied. It rises one cycle after the completion that satisfies the last pending source.
- R8: A kill_mask bit frees its entry: issue_ready drops the next cycle, and later completions do not raise it.
- R9: A source whose register completes in the same cycle as the insertion is treated as ready.
- R10: If a register is allocated and completed in the same cycle, it ends not ready. The allocation wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Destination allocation strobe |
| alloc_preg | input | TAG_W | Allocated register index |
| alloc_conflict | output | 1 | Allocated register still has dependents |
| ins_valid | input | 1 | Insertion strobe |
| ins_entry | input | ENT_W | Entry written by the insertion |
| ins_src | input | NUM_SRC*TAG_W | Source tags, source s in field s |
| ins_src_rdy | input | NUM_SRC | Per-source ready flag from the earlier stage |
| cmp_valid | input | NUM_CMP | Completion port strobes |
| cmp_preg | input | NUM_CMP*TAG_W | Completed register per port |
| kill_mask | input | NUM_ENTRIES | Entries to remove |
| issue_ready | output | NUM_ENTRIES | Entry has all sources ready |
| preg_ready | output | NUM_PREGS | Register ready bits |

## Verification
The bench targets a completion that lands in the same cycle as the insertion of its consumer. A design that misses this case leaves the entry waiting forever, and issue_ready never rises. It also inserts sources that became ready while between stages, which a design without the second scoreboard read would park. Untracked tags are probed as well: a design that compared them would wait on them or raise preg_ready. Kills followed by completion of the killed entry's source are tested, which catches stale wakeups. Allocation and completion of one register in the same cycle are tested too, which catches a design that lets the completion win.

// File: rtl/wk_pkg.sv
package wk_pkg;
    typedef enum logic [1:0] {
        E_FREE  = 2'd0,
        E_WAIT  = 2'd1,
        E_READY = 2'd2
    } ent_state_e;
endpackage

// File: rtl/wk_ready_bits.sv
module wk_ready_bits #(
    parameter int NUM_PREGS = 16,
    parameter int NUM_CMP   = 2,
    parameter int TAG_W     = $clog2(NUM_PREGS) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic [TAG_W-1:0]         alloc_preg,
    input  logic [NUM_CMP-1:0]       cmp_valid,
    input  logic [NUM_CMP*TAG_W-1:0] cmp_preg,
    output logic [NUM_PREGS-1:0]     ready
);
    logic [NUM_PREGS-1:0] rdy_q;
    logic [NUM_PREGS-1:0] set_v;
    logic [NUM_PREGS-1:0] clr_v;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        for (int r = 0; r < NUM_PREGS; r++) begin
            for (int c = 0; c < NUM_CMP; c++) begin
                if (cmp_valid[c] && int'(cmp_preg[c*TAG_W +: TAG_W]) == r)
                    set_v[r] = 1'b1;
            end
            if (alloc_valid && int'(alloc_preg) == r)
                clr_v[r] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= '0;
        else        rdy_q <= (rdy_q | set_v) & ~clr_v;
    end

    always_comb ready = rdy_q;

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_chk
        a_r2_alloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_valid && int'(alloc_preg) == r) |=> !rdy_q[r]);
        a_r6_cmp_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v[r] && !(alloc_valid && int'(alloc_preg) == r)) |=> rdy_q[r]);
    end
endmodule

// File: rtl/wk_entry.sv
module wk_entry
    import wk_pkg::*;
#(
    parameter int NUM_PREGS = 16,
    parameter int NUM_SRC   = 2,
    parameter int NUM_CMP   = 2,
    parameter int TAG_W     = $clog2(NUM_PREGS) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_we,
    input  logic [NUM_SRC*TAG_W-1:0] ins_tag,
    input  logic [NUM_SRC-1:0]       ins_wait,
    input  logic [NUM_CMP-1:0]       cmp_valid,
    input  logic [NUM_CMP*TAG_W-1:0] cmp_preg,
    input  logic                     kill,
    output logic                     ready,
    output logic [NUM_SRC-1:0]       wait_o,
    output logic [NUM_SRC*TAG_W-1:0] tag_o
);
    ent_state_e                state_q, state_d;
    logic [NUM_SRC-1:0]        wait_q, wait_d;
    logic [NUM_SRC*TAG_W-1:0]  tag_q, tag_d;

    always_comb begin
        wait_d = wait_q;
        tag_d  = tag_q;
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int c = 0; c < NUM_CMP; c++) begin
                if (cmp_valid[c] && cmp_preg[c*TAG_W +: TAG_W] == tag_q[s*TAG_W +: TAG_W])
                    wait_d[s] = 1'b0;
            end
        end
        unique case (state_q)
            E_FREE:  state_d = E_FREE;
            E_WAIT:  state_d = (wait_d == '0) ? E_READY : E_WAIT;
            E_READY: state_d = E_READY;
            default: state_d = E_FREE;
        endcase
        if (kill) begin
            state_d = E_FREE;
            wait_d  = '0;
        end
        if (ins_we) begin
            wait_d  = ins_wait;
            tag_d   = ins_tag;
            state_d = (ins_wait == '0) ? E_READY : E_WAIT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= E_FREE;
            wait_q  <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            wait_q  <= wait_d;
            tag_q   <= tag_d;
        end
    end

    always_comb begin
        ready  = (state_q == E_READY);
        wait_o = wait_q;
        tag_o  = tag_q;
    end

    a_r7_ready_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_READY) |-> (wait_q == '0));
    a_r8_kill_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (kill && !ins_we) |=> (state_q == E_FREE));
    a_r8_free_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == E_FREE) |-> (wait_q == '0));
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        a_r5_tracked_only: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q[s] |-> (int'(tag_q[s*TAG_W +: TAG_W]) < NUM_PREGS));
        a_r6_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_q[s] && !kill && !ins_we && cmp_valid == '0) |=> wait_q[s]);
    end
endmodule

// File: rtl/preg_wakeup_sb.sv
module preg_wakeup_sb #(
    parameter int NUM_PREGS   = 16,
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_SRC     = 2,
    parameter int NUM_CMP     = 2,
    parameter int TAG_W       = $clog2(NUM_PREGS) + 1,
    parameter int ENT_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_valid,
    input  logic [TAG_W-1:0]         alloc_preg,
    output logic                     alloc_conflict,
    input  logic                     ins_valid,
    input  logic [ENT_W-1:0]         ins_entry,
    input  logic [NUM_SRC*TAG_W-1:0] ins_src,
    input  logic [NUM_SRC-1:0]       ins_src_rdy,
    input  logic [NUM_CMP-1:0]       cmp_valid,
    input  logic [NUM_CMP*TAG_W-1:0] cmp_preg,
    input  logic [NUM_ENTRIES-1:0]   kill_mask,
    output logic [NUM_ENTRIES-1:0]   issue_ready,
    output logic [NUM_PREGS-1:0]     preg_ready
);
    logic [NUM_SRC-1:0]       ins_wait;
    logic [NUM_SRC-1:0]       ent_wait [NUM_ENTRIES];
    logic [NUM_SRC*TAG_W-1:0] ent_tag  [NUM_ENTRIES];

    wk_ready_bits #(.NUM_PREGS(NUM_PREGS), .NUM_CMP(NUM_CMP), .TAG_W(TAG_W)) u_bits (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
        .cmp_valid(cmp_valid), .cmp_preg(cmp_preg),
        .ready(preg_ready)
    );

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            logic [TAG_W-1:0] t;
            logic             seen;
            t    = ins_src[s*TAG_W +: TAG_W];
            seen = 1'b0;
            for (int r = 0; r < NUM_PREGS; r++)
                if (int'(t) == r && preg_ready[r]) seen = 1'b1;
            for (int c = 0; c < NUM_CMP; c++)
                if (cmp_valid[c] && cmp_preg[c*TAG_W +: TAG_W] == t) seen = 1'b1;
            ins_wait[s] = !ins_src_rdy[s] && (int'(t) < NUM_PREGS) && !seen;
        end
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        wk_entry #(.NUM_PREGS(NUM_PREGS), .NUM_SRC(NUM_SRC), .NUM_CMP(NUM_CMP), .TAG_W(TAG_W)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .ins_we(ins_valid && int'(ins_entry) == e),
            .ins_tag(ins_src), .ins_wait(ins_wait),
            .cmp_valid(cmp_valid), .cmp_preg(cmp_preg),
            .kill(kill_mask[e]),
            .ready(issue_ready[e]), .wait_o(ent_wait[e]), .tag_o(ent_tag[e])
        );
    end

    always_comb begin
        alloc_conflict = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++)
            for (int s = 0; s < NUM_SRC; s++)
                if (alloc_valid && ent_wait[e][s] && ent_tag[e][s*TAG_W +: TAG_W] == alloc_preg)
                    alloc_conflict = 1'b1;
    end

    a_r3_conflict_needs_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_conflict |-> alloc_valid);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (issue_ready == '0 && preg_ready == '0));
endmodule

// File: tb/preg_wakeup_sb_tb.sv
`timescale 1ns/1ps
module preg_wakeup_sb_tb;
    localparam int NP = 16, NE = 8, NS = 2, NC = 2, TW = 5, EW = 3;

    logic clk = 0, rst_n = 0;
    logic alloc_valid = 0;
    logic [TW-1:0] alloc_preg = '0;
    logic alloc_conflict;
    logic ins_valid = 0;
    logic [EW-1:0] ins_entry = '0;
    logic [NS*TW-1:0] ins_src = '0;
    logic [NS-1:0] ins_src_rdy = '0;
    logic [NC-1:0] cmp_valid = '0;
    logic [NC*TW-1:0] cmp_preg = '0;
    logic [NE-1:0] kill_mask = '0;
    logic [NE-1:0] issue_ready;
    logic [NP-1:0] preg_ready;

    int checks = 0, errors = 0;
    int m_sb [NP];
    int m_busy [NE];
    int m_wt [NE][NS];
    int m_tg [NE][NS];

    always #5 clk = ~clk;

    preg_wakeup_sb #(.NUM_PREGS(NP), .NUM_ENTRIES(NE), .NUM_SRC(NS), .NUM_CMP(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_preg(alloc_preg),
        .alloc_conflict(alloc_conflict), .ins_valid(ins_valid), .ins_entry(ins_entry),
        .ins_src(ins_src), .ins_src_rdy(ins_src_rdy), .cmp_valid(cmp_valid),
        .cmp_preg(cmp_preg), .kill_mask(kill_mask), .issue_ready(issue_ready),
        .preg_ready(preg_ready));

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic bit m_cmp_hit(input int t);
        for (int c = 0; c < NC; c++)
            if (cmp_valid[c] && int'(cmp_preg[c*TW +: TW]) == t) return 1;
        return 0;
    endfunction

    function automatic logic [NE-1:0] m_issue();
        logic [NE-1:0] v = '0;
        for (int e = 0; e < NE; e++) begin
            bit any = 0;
            for (int s = 0; s < NS; s++) if (m_wt[e][s] != 0) any = 1;
            v[e] = (m_busy[e] != 0) && !any;
        end
        return v;
    endfunction

    function automatic logic [NP-1:0] m_pregs();
        logic [NP-1:0] v = '0;
        for (int r = 0; r < NP; r++) v[r] = (m_sb[r] != 0);
        return v;
    endfunction

    function automatic bit m_conflict();
        if (!alloc_valid) return 0;
        for (int e = 0; e < NE; e++)
            for (int s = 0; s < NS; s++)
                if (m_busy[e] != 0 && m_wt[e][s] != 0 && m_tg[e][s] == int'(alloc_preg)) return 1;
        return 0;
    endfunction

    task automatic model_edge();
        int nw [NS];
        for (int s = 0; s < NS; s++) begin
            int t = int'(ins_src[s*TW +: TW]);
            nw[s] = (!ins_src_rdy[s] && t < NP && m_sb[t] == 0 && !m_cmp_hit(t)) ? 1 : 0;
        end
        for (int e = 0; e < NE; e++) begin
            for (int s = 0; s < NS; s++)
                if (m_wt[e][s] != 0 && m_cmp_hit(m_tg[e][s])) m_wt[e][s] = 0;
            if (kill_mask[e]) begin
                m_busy[e] = 0;
                for (int s = 0; s < NS; s++) m_wt[e][s] = 0;
            end
            if (ins_valid && int'(ins_entry) == e) begin
                m_busy[e] = 1;
                for (int s = 0; s < NS; s++) begin
                    m_wt[e][s] = nw[s];
                    m_tg[e][s] = int'(ins_src[s*TW +: TW]);
                end
            end
        end
        for (int r = 0; r < NP; r++) if (m_cmp_hit(r)) m_sb[r] = 1;
        if (alloc_valid && int'(alloc_preg) < NP) m_sb[int'(alloc_preg)] = 0;
    endtask

    // Inputs are set at a negedge before calling; this advances one cycle.
    task automatic cycle();
        #1;
        check({31'd0, alloc_conflict}, {31'd0, m_conflict()}, "R3 conflict");
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({24'd0, issue_ready}, {24'd0, m_issue()}, "R7 issue_ready model");
        check({16'd0, preg_ready}, {16'd0, m_pregs()}, "R2 preg_ready model");
        alloc_valid = 0; ins_valid = 0; cmp_valid = '0; kill_mask = '0; ins_src_rdy = '0;
    endtask

    task automatic do_ins(input int e, input int t0, input int t1, input logic [1:0] rdy);
        ins_valid = 1; ins_entry = EW'(e);
        ins_src = {TW'(t1), TW'(t0)}; ins_src_rdy = rdy;
    endtask

    task automatic do_cmp(input int port, input int t);
        cmp_valid[port] = 1; cmp_preg[port*TW +: TW] = TW'(t);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < NP; r++) m_sb[r] = 0;
        for (int e = 0; e < NE; e++) begin
            m_busy[e] = 0;
            for (int s = 0; s < NS; s++) begin m_wt[e][s] = 0; m_tg[e][s] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        check({16'd0, preg_ready}, 32'd0, "R1 reset pregs");
        check({24'd0, issue_ready}, 32'd0, "R1 reset entries");

        do_cmp(0, 3); cycle();
        check({31'd0, preg_ready[3]}, 32'd1, "R6 completion sets");
        alloc_valid = 1; alloc_preg = 5'd3; cycle();
        check({31'd0, preg_ready[3]}, 32'd0, "R2 alloc clears");
        do_ins(0, 3, 20, 2'b00); cycle();
        check({31'd0, issue_ready[0]}, 32'd0, "R7 waits on pending source");
        alloc_valid = 1; alloc_preg = 5'd3; #1;
        check({31'd0, alloc_conflict}, 32'd1, "R3 conflict raised");
        cycle();
        do_cmp(1, 20); cycle();
        check({31'd0, issue_ready[0]}, 32'd0, "R5 untracked completion no effect");
        check({16'd0, preg_ready}, 32'd0, "R5 untracked no ready bit");
        do_cmp(0, 3); cycle();
        check({31'd0, issue_ready[0]}, 32'd1, "R7 ready after last source");
        do_cmp(0, 5); cycle();
        do_ins(1, 5, 6, 2'b10); cycle();
        check({31'd0, issue_ready[1]}, 32'd1, "R4 scoreboard recheck and flagged ready");
        do_ins(2, 7, 7, 2'b00); do_cmp(1, 7); cycle();
        check({31'd0, issue_ready[2]}, 32'd1, "R9 same-cycle completion");
        do_ins(3, 8, 9, 2'b00); cycle();
        do_cmp(0, 8); cycle();
        check({31'd0, issue_ready[3]}, 32'd0, "R7 one source still pending");
        do_cmp(0, 9); cycle();
        check({31'd0, issue_ready[3]}, 32'd1, "R7 both sources done");
        do_ins(4, 10, 10, 2'b00); cycle();
        kill_mask[4] = 1; kill_mask[0] = 1; cycle();
        check({31'd0, issue_ready[0]}, 32'd0, "R8 kill drops ready");
        do_cmp(0, 10); cycle();
        check({31'd0, issue_ready[4]}, 32'd0, "R8 killed entry not woken");
        alloc_valid = 1; alloc_preg = 5'd11; do_cmp(0, 11); cycle();
        check({31'd0, preg_ready[11]}, 32'd0, "R10 alloc wins");
        do_ins(5, 12, 13, 2'b00); cycle();
        do_cmp(0, 12); do_cmp(1, 13); cycle();
        check({31'd0, issue_ready[5]}, 32'd1, "R6 parallel ports");
        check({30'd0, preg_ready[13], preg_ready[12]}, 32'd3, "R6 both bits set");

        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(0, 3) == 0) begin alloc_valid = 1; alloc_preg = TW'($urandom_range(0, 19)); end
            if ($urandom_range(0, 1) == 0)
                do_ins(int'($urandom_range(0, NE-1)), int'($urandom_range(0, 19)),
                       int'($urandom_range(0, 19)), 2'($urandom_range(0, 3)));
            for (int c = 0; c < NC; c++)
                if ($urandom_range(0, 2) == 0) do_cmp(c, int'($urandom_range(0, 19)));
            if ($urandom_range(0, 5) == 0) kill_mask = NE'($urandom);
            cycle();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule